// File: doc/BRIEF.md
# Three-Level Timestamp Interval Calculator

This block sits behind an external time-to-digital converter that reports one timestamp per hit. Every hit arrives as three codes: a coarse count (800 ps per step, carried as a low byte and a high byte over two separate paths), a fine count (100 ps per step) and a Vernier count (12.5 ps per step). The codes are taken only in a cycle where the converter's output-enable strobe is high. The block joins the two coarse parts and weights the three levels into one 22-bit timestamp in 12.5 ps units. It then subtracts the timestamp of the previous accepted hit, so the result is the time between adjacent hits.

The subtraction is taken modulo 2^22, so a coarse-counter rollover between two hits still gives the right interval, as long as the true gap is shorter than one full coarse period. Each result leaves on a valid/ready stream toward the host link, together with an error bit. If a result finds the output still stalled, it is dropped and a sticky overflow flag is set. A synchronous clear puts the block back into its just-reset condition.

Top module: `tdc_interval_calc`

## Requirements
- R1: After reset, `res_valid` and `overrun` are 0.
- R2: The coarse value is `{crs_hi, crs_lo}`: `crs_lo` holds bits 7..0 and `crs_hi` holds bits 15..8.
- R3: A hit's timestamp is coarse*64 + fine*8 + vernier, kept as 22 bits.
- R4: The first in-range hit after reset or after a clear only stores its timestamp as the reference. It produces no result.
- R5: Every later in-range hit produces `res_ival` = (timestamp − reference) mod 2^22 with `res_err` = 0. The result is visible in the cycle after the strobe cycle, and the hit then becomes the new reference.
- R6: While `code_stb` is low, the code inputs have no effect.
- R7: A hit whose Vernier value is above 7 produces a result with `res_err` = 1 and `res_ival` = 0. It leaves the reference unchanged.
- R8: While `res_valid` is 1 and `res_rdy` is 0, `res_valid`, `res_ival` and `res_err` hold their values.
- R9: A result that arrives while the output is stalled is dropped and sets `overrun`. `overrun` stays set until a clear, and the dropped hit still becomes the reference.
- R10: `clr` empties the output, clears `overrun` and forgets the reference. It wins over a strobe in the same cycle.
- R11: If the held result is accepted in the same cycle that a new result arrives, the new result is loaded and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of reference, output and flag |
| code_stb | input | 1 | Output-enable strobe from the converter |
| crs_lo | input | 8 | Low-order coarse part |
| crs_hi | input | 8 | High-order coarse part |
| fine_code | input | 3 | Fine code, 100 ps per step |
| vern_code | input | 4 | Vernier code, 12.5 ps per step |
| res_valid | output | 1 | Result valid |
| res_rdy | input | 1 | Downstream ready |
| res_ival | output | 22 | Interval in 12.5 ps units |
| res_err | output | 1 | Result comes from an out-of-range hit |
| overrun | output | 1 | Sticky: a result was lost while the output stalled |

## Verification
Two things can happen in the same cycle: the downstream accepts the held result, and a new hit arrives that produces another result. The bench holds `res_rdy` low until a result is waiting. It then raises `res_rdy` in the same cycle as the next strobe. The check is that the new interval replaces the old one and that `overrun` stays 0. The opposite case, a strobe while `res_rdy` stays low, must set `overrun` and keep the old result unchanged.

// File: rtl/tdc_ts_pkg.sv
package tdc_ts_pkg;
    // Default field widths of the converter code
    localparam int unsigned CRS_PART_W = 8;
    localparam int unsigned FINE_W     = 3;
    localparam int unsigned VERN_W     = 4;
    // Vernier steps per fine step, fine steps per coarse step
    localparam int unsigned VERN_PER_FINE = 8;
    localparam int unsigned FINE_PER_CRS  = 8;
    // Largest legal Vernier code
    localparam int unsigned VERN_MAX = VERN_PER_FINE - 1;
endpackage

// File: rtl/tdc_code_merge.sv
module tdc_code_merge #(
    parameter int unsigned PART_W        = tdc_ts_pkg::CRS_PART_W,
    parameter int unsigned FINE_W        = tdc_ts_pkg::FINE_W,
    parameter int unsigned VERN_W        = tdc_ts_pkg::VERN_W,
    parameter int unsigned VERN_PER_FINE = tdc_ts_pkg::VERN_PER_FINE,
    parameter int unsigned FINE_PER_CRS  = tdc_ts_pkg::FINE_PER_CRS,
    parameter int unsigned VERN_MAX      = tdc_ts_pkg::VERN_MAX,
    parameter int unsigned TS_W          = 2*PART_W + $clog2(VERN_PER_FINE*FINE_PER_CRS)
) (
    input  logic [PART_W-1:0] crs_lo,
    input  logic [PART_W-1:0] crs_hi,
    input  logic [FINE_W-1:0] fine,
    input  logic [VERN_W-1:0] vern,
    output logic [TS_W-1:0]   ts,
    output logic              bad
);
    localparam int unsigned CRS_W   = 2*PART_W;
    localparam int unsigned W_FINE  = VERN_PER_FINE;
    localparam int unsigned W_CRS   = VERN_PER_FINE*FINE_PER_CRS;

    logic [CRS_W-1:0] coarse;
    logic [TS_W-1:0]  crs_ext, fine_ext, vern_ext;

    // Low part from the fast path, high part from the slow path
    assign coarse   = {crs_hi, crs_lo};
    assign crs_ext  = TS_W'(coarse);
    assign fine_ext = TS_W'(fine);
    assign vern_ext = TS_W'(vern);

    // Weighted sum in finest units
    assign ts = TS_W'(crs_ext * TS_W'(W_CRS)) + TS_W'(fine_ext * TS_W'(W_FINE)) + vern_ext;

    // Range check only exists when the code can exceed the legal maximum
    generate
        if (VERN_MAX >= (2**VERN_W) - 1) begin : g_no_check
            assign bad = 1'b0;
        end else begin : g_check
            assign bad = (vern > VERN_W'(VERN_MAX));
        end
    endgenerate
endmodule

// File: rtl/tdc_mod_delta.sv
module tdc_mod_delta #(
    parameter int unsigned TS_W = 22
) (
    input  logic [TS_W-1:0] cur,
    input  logic [TS_W-1:0] prev,
    output logic [TS_W-1:0] delta
);
    // Natural truncation gives the difference modulo 2^TS_W
    assign delta = cur - prev;
endmodule

// File: rtl/tdc_interval_calc.sv
module tdc_interval_calc #(
    parameter int unsigned PART_W        = tdc_ts_pkg::CRS_PART_W,
    parameter int unsigned FINE_W        = tdc_ts_pkg::FINE_W,
    parameter int unsigned VERN_W        = tdc_ts_pkg::VERN_W,
    parameter int unsigned VERN_PER_FINE = tdc_ts_pkg::VERN_PER_FINE,
    parameter int unsigned FINE_PER_CRS  = tdc_ts_pkg::FINE_PER_CRS,
    parameter int unsigned VERN_MAX      = tdc_ts_pkg::VERN_MAX,
    parameter int unsigned TS_W          = 2*PART_W + $clog2(VERN_PER_FINE*FINE_PER_CRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              code_stb,
    input  logic [PART_W-1:0] crs_lo,
    input  logic [PART_W-1:0] crs_hi,
    input  logic [FINE_W-1:0] fine_code,
    input  logic [VERN_W-1:0] vern_code,
    output logic              res_valid,
    input  logic              res_rdy,
    output logic [TS_W-1:0]   res_ival,
    output logic              res_err,
    output logic              overrun
);
    typedef struct packed {
        logic            have_ref;
        logic [TS_W-1:0] ref_ts;
        logic            vld;
        logic [TS_W-1:0] ival;
        logic            err;
        logic            ovf;
    } st_t;

    st_t st_d, st_q;

    logic [TS_W-1:0] hit_ts;
    logic            hit_bad;
    logic [TS_W-1:0] hit_delta;
    logic            have_ref_q;

    tdc_code_merge #(
        .PART_W(PART_W), .FINE_W(FINE_W), .VERN_W(VERN_W),
        .VERN_PER_FINE(VERN_PER_FINE), .FINE_PER_CRS(FINE_PER_CRS),
        .VERN_MAX(VERN_MAX), .TS_W(TS_W)
    ) u_merge (
        .crs_lo(crs_lo), .crs_hi(crs_hi), .fine(fine_code), .vern(vern_code),
        .ts(hit_ts), .bad(hit_bad)
    );

    tdc_mod_delta #(.TS_W(TS_W)) u_delta (
        .cur(hit_ts), .prev(st_q.ref_ts), .delta(hit_delta)
    );

    always_comb begin
        logic            slot_free;
        logic            emit;
        logic [TS_W-1:0] e_ival;
        logic            e_err;

        st_d      = st_q;
        slot_free = !st_q.vld || res_rdy;
        emit      = 1'b0;
        e_ival    = '0;
        e_err     = 1'b0;

        if (slot_free) begin
            st_d.vld = 1'b0;
        end

        if (clr) begin
            st_d = '0;
        end else if (code_stb) begin
            if (hit_bad) begin
                emit  = 1'b1;
                e_err = 1'b1;
            end else if (!st_q.have_ref) begin
                st_d.have_ref = 1'b1;
                st_d.ref_ts   = hit_ts;
            end else begin
                emit        = 1'b1;
                e_ival      = hit_delta;
                st_d.ref_ts = hit_ts;
            end

            if (emit) begin
                if (slot_free) begin
                    st_d.vld  = 1'b1;
                    st_d.ival = e_ival;
                    st_d.err  = e_err;
                end else begin
                    st_d.ovf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.vld;
    assign res_ival   = st_q.ival;
    assign res_err    = st_q.err;
    assign overrun    = st_q.ovf;
    assign have_ref_q = st_q.have_ref;
endmodule

// File: rtl/tdc_interval_calc_chk.sv
module tdc_interval_calc_chk #(
    parameter int unsigned VERN_W   = 4,
    parameter int unsigned VERN_MAX = 7,
    parameter int unsigned TS_W     = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              code_stb,
    input logic [VERN_W-1:0] vern_code,
    input logic              res_valid,
    input logic              res_rdy,
    input logic [TS_W-1:0]   res_ival,
    input logic              res_err,
    input logic              overrun,
    input logic              have_ref_q
);
    logic in_range;
    logic stalled;
    assign in_range = (vern_code <= VERN_W'(VERN_MAX));
    assign stalled  = res_valid && !res_rdy;

    AST_FIRST_LOADS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (code_stb && !clr && in_range && !have_ref_q && !stalled) |=> !res_valid); // R4

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_stb && !clr && in_range && have_ref_q && !stalled) |=> (res_valid && !res_err)); // R5

    AST_ERR_ZERO_IVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |-> (res_ival == '0)); // R7

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !clr) |=> (res_valid && $stable(res_ival) && $stable(res_err))); // R8

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (code_stb && !clr && stalled && (have_ref_q || !in_range)) |=> overrun); // R9

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr) |=> overrun); // R9

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!res_valid && !overrun && !have_ref_q)); // R10

    AST_NO_OVERRUN_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_rdy && !overrun && !clr) |=> !overrun); // R11
endmodule

bind tdc_interval_calc tdc_interval_calc_chk #(
    .VERN_W(VERN_W), .VERN_MAX(VERN_MAX), .TS_W(TS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .code_stb(code_stb),
    .vern_code(vern_code), .res_valid(res_valid), .res_rdy(res_rdy),
    .res_ival(res_ival), .res_err(res_err), .overrun(overrun),
    .have_ref_q(have_ref_q)
);

// File: tb/tdc_interval_calc_tb.sv
`timescale 1ns/1ps
module tdc_interval_calc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        code_stb = 1'b0;
    logic [7:0]  crs_lo = '0;
    logic [7:0]  crs_hi = '0;
    logic [2:0]  fine_code = '0;
    logic [3:0]  vern_code = '0;
    logic        res_rdy = 1'b1;
    logic        res_valid;
    logic [21:0] res_ival;
    logic        res_err;
    logic        overrun;

    int n_chk = 0;
    int n_bad = 0;
    logic        have_ref = 1'b0;
    logic [21:0] ref_ts = '0;
    logic [21:0] last_ival = '0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    tdc_interval_calc u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .code_stb(code_stb),
        .crs_lo(crs_lo), .crs_hi(crs_hi), .fine_code(fine_code), .vern_code(vern_code),
        .res_valid(res_valid), .res_rdy(res_rdy), .res_ival(res_ival),
        .res_err(res_err), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] ts_of(input logic [15:0] c, input logic [2:0] f, input logic [3:0] v);
        return 22'(c) * 22'd64 + 22'(f) * 22'd8 + 22'(v); // R3 weighting
    endfunction

    // Drives one strobed hit; returns at the next negedge, when the result is visible
    task automatic hit(input logic [15:0] c, input logic [2:0] f, input logic [3:0] v);
        crs_lo = c[7:0]; crs_hi = c[15:8]; fine_code = f; vern_code = v;
        code_stb = 1'b1;
        @(negedge clk);
        code_stb = 1'b0;
    endtask

    // Hit with the bench model updated and the output checked (ready high)
    task automatic hit_chk(input string req, input logic [15:0] c, input logic [2:0] f, input logic [3:0] v);
        logic [21:0] t;
        t = ts_of(c, f, v);
        hit(c, f, v);
        if (v > 4'd7) begin
            chk({req, " err valid"}, 32'(res_valid), 32'd1);
            chk({req, " err flag"}, 32'(res_err), 32'd1);
            chk({req, " err ival"}, 32'(res_ival), 32'd0);
        end else if (!have_ref) begin
            chk({req, " first no result"}, 32'(res_valid), 32'd0);
            have_ref = 1'b1; ref_ts = t;
        end else begin
            chk({req, " valid"}, 32'(res_valid), 32'd1);
            chk({req, " err clear"}, 32'(res_err), 32'd0);
            chk({req, " interval"}, 32'(res_ival), 32'(22'(t - ref_ts)));
            ref_ts = t;
        end
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        have_ref = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        repeat (3) @(negedge clk);
        chk("R1 valid after reset", 32'(res_valid), 32'd0);
        chk("R1 overrun after reset", 32'(overrun), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R5: sweep all fine and Vernier codes, with several coarse steps
        hit_chk("R4", 16'd100, 3'd0, 4'd0);
        c = 16'd100;
        for (int f = 0; f < 8; f++) begin
            for (int v = 0; v < 8; v++) begin
                c = c + 16'(f) + 16'(v % 3);
                hit_chk("R3 R5 sweep", c, 3'(f), 4'(v));
            end
        end
        // R2: high and low parts in distinct positions
        hit_chk("R2 low part", 16'h12FF, 3'd1, 4'd2);
        hit_chk("R2 high part", 16'h1300, 3'd0, 4'd0);
        hit_chk("R2 both", 16'hA55A, 3'd4, 4'd3);

        // R5 wrap: counter rolls over between hits
        hit_chk("R5 pre-wrap", 16'hFFFF, 3'd7, 4'd7);
        hit_chk("R5 wrap", 16'h0000, 3'd0, 4'd1);
        hit_chk("R5 pre-wrap2", 16'hFFF0, 3'd2, 4'd5);
        hit_chk("R5 wrap2", 16'h0010, 3'd1, 4'd0);

        // R6: code inputs move without strobe
        crs_lo = 8'hAA; crs_hi = 8'h55; fine_code = 3'd6; vern_code = 4'd9;
        repeat (3) @(negedge clk);
        chk("R6 no result without strobe", 32'(res_valid), 32'd0);
        hit_chk("R6 reference kept", 16'h0020, 3'd3, 4'd3);

        // R7: every out-of-range Vernier code
        for (int v = 8; v < 16; v++) begin
            hit_chk("R7", 16'h4000, 3'd5, 4'(v));
        end
        hit_chk("R7 reference unchanged", 16'h0030, 3'd0, 4'd0);

        // R4/R10: clear at the same time as a strobe
        clr = 1'b1;
        hit(16'h0100, 3'd0, 4'd0);
        clr = 1'b0;
        have_ref = 1'b0;
        chk("R10 clear beats strobe", 32'(res_valid), 32'd0);
        hit_chk("R4 after clear", 16'h0200, 3'd2, 4'd2);
        hit_chk("R4 next after clear", 16'h0203, 3'd1, 4'd7);

        // R7 during first-hit state: error still reported
        do_clear();
        hit_chk("R7 before reference", 16'h0001, 3'd0, 4'd12);
        hit_chk("R4 after error", 16'h0005, 3'd0, 4'd0);

        // R8/R9: stall, then overrun
        res_rdy = 1'b0;
        hit_chk("R8 stalled result", 16'h0009, 3'd1, 4'd1);
        last_ival = 22'(ts_of(16'h0009, 3'd1, 4'd1) - ts_of(16'h0005, 3'd0, 4'd0));
        repeat (2) @(negedge clk);
        chk("R8 held valid", 32'(res_valid), 32'd1);
        chk("R8 held ival", 32'(res_ival), 32'(last_ival));
        chk("R9 no overrun yet", 32'(overrun), 32'd0);
        hit(16'h0020, 3'd0, 4'd0);
        ref_ts = ts_of(16'h0020, 3'd0, 4'd0);
        chk("R9 overrun set", 32'(overrun), 32'd1);
        chk("R9 old result kept", 32'(res_ival), 32'(last_ival));
        res_rdy = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 overrun sticky", 32'(overrun), 32'd1);
        hit_chk("R9 dropped hit is reference", 16'h0021, 3'd0, 4'd4);

        // R11: accept and new result in the same cycle
        do_clear();
        chk("R10 overrun cleared", 32'(overrun), 32'd0);
        res_rdy = 1'b0;
        hit_chk("R11 setup ref", 16'h0040, 3'd0, 4'd0);
        hit_chk("R11 setup held", 16'h0041, 3'd0, 4'd0);
        res_rdy = 1'b1;
        hit(16'h0043, 3'd2, 4'd6);
        chk("R11 new valid", 32'(res_valid), 32'd1);
        chk("R11 new ival", 32'(res_ival), 32'(22'(ts_of(16'h0043, 3'd2, 4'd6) - ref_ts)));
        chk("R11 no overrun", 32'(overrun), 32'd0);
        ref_ts = ts_of(16'h0043, 3'd2, 4'd6);
        @(negedge clk);
        chk("R11 drained", 32'(res_valid), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule